// File: doc/BRIEF.md
# Major/Minor State Control Sequencer

This block is the timing core of a hardwired control unit for a 16-bit accumulator machine. A modulo-4 minor-step timer produces four one-hot step pulses, and a major-state register moves through three phases: instruction fetch, operand deferral (indirect addressing) and execution. Each phase that is entered lasts exactly four steps. The block reads the instruction register contents and an I/O completion flag. From the opcode and the major state it decides which phase follows at the close of the fourth step.

Alongside the phase timing, the block decodes the 4-bit opcode into sixteen one-hot lines and drives the bus-source, ALU-function and register-load strobes of the fetch and deferral phases. Memory read data is consumed two steps after the read is issued. Control signals specific to the execution phase belong to other logic, with one exception: the block keeps an I/O instruction in the execution phase until the device reports that it is done.

Top module: `phase_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block enters fetch step 1 (`minor_pulse` = 4'b0001, `major_state` = 2'b00).
- R2: `minor_pulse` is always one-hot and advances one bit position per clock, from bit 0 (step 1) to bit 3 (step 4) and then back to bit 0.
- R3: `major_state` encodes fetch as 2'b00, deferral as 2'b01 and execution as 2'b10. It changes only at the clock edge that ends step 4, and deferral is always followed by execution.
- R4: At the end of fetch step 4, opcodes 0, 10 and 11 (instruction bits 15:12) stay in fetch. A one-operand opcode (1, 2, 3, 5, 6, 7, 12, 13, 14, 15) with instruction bit 10 set goes to deferral. Every other case goes to execution.
- R5: At the end of execution step 4, opcodes 8 and 9 stay in execution while `io_done` is low. Any other opcode, or `io_done` high, returns to fetch.
- R6: `op_line[k]` is high exactly when instruction bits 15:12 equal k, combinationally and at all times.
- R7: In fetch step 1, exactly `mem_read`, `pc_to_bus1`, `alu_pass1` and `bus3_to_mar` are high.
- R8: In fetch step 2, exactly `pc_to_bus1`, `one_to_bus2`, `alu_add` and `bus3_to_pc` are high.
- R9: In fetch step 3, exactly `mbr_to_bus2`, `alu_pass2` and `bus3_to_ir` are high.
- R10: In fetch step 4, a one-operand opcode raises `irlo_to_bus1` and `bus3_to_mar`, plus `idx_to_bus2` and `alu_add` if instruction bit 15 is 0, or `alu_pass1` if it is 1. Any other opcode raises no strobe.
- R11: In deferral, step 1 raises only `mem_read` and step 3 raises only `mbr_to_bus2`, `alu_pass2` and `bus3_to_mar`. Deferral steps 2 and 4, and all execution steps, raise no strobe.
- R12: Every `mem_read` is followed, exactly two clocks later, by `mbr_to_bus2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one minor step per cycle |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 16 | Instruction register contents |
| io_done | input | 1 | I/O transfer complete flag |
| minor_pulse | output | 4 | One-hot minor step, bit 0 = step 1 |
| major_state | output | 2 | Current phase: 00 fetch, 01 deferral, 10 execution |
| op_line | output | 16 | One-hot decoded opcode lines |
| mem_read | output | 1 | Start a memory read |
| pc_to_bus1 | output | 1 | Program counter drives ALU input bus 1 |
| one_to_bus2 | output | 1 | Constant one drives ALU input bus 2 |
| irlo_to_bus1 | output | 1 | Instruction address field drives bus 1 |
| idx_to_bus2 | output | 1 | Selected index register drives bus 2 |
| mbr_to_bus2 | output | 1 | Memory buffer drives bus 2 |
| alu_pass1 | output | 1 | ALU passes bus 1 to the result bus |
| alu_pass2 | output | 1 | ALU passes bus 2 to the result bus |
| alu_add | output | 1 | ALU adds bus 1 and bus 2 |
| bus3_to_mar | output | 1 | Result bus loads the memory address register |
| bus3_to_pc | output | 1 | Result bus loads the program counter |
| bus3_to_ir | output | 1 | Result bus loads the instruction register |

## Verification
Strobes and opcode lines are combinational from the registered step and phase, so they are due in the same cycle as the instruction value they depend on. The bench compares them 1 ns after it changes its inputs on the falling edge. Step and phase changes come from one register stage and are due one rising edge after the inputs that decide them. The behavioural reference therefore advances its own step and phase on each rising edge and is compared on the following falling edge. The read-to-buffer latency is checked against a two-deep history of the observed `mem_read`, which is cleared on every reset.

// File: rtl/phseq_pkg.sv
package phseq_pkg;

   typedef enum logic [1:0] {
      MAJ_FETCH = 2'b00,
      MAJ_DEFER = 2'b01,
      MAJ_EXEC  = 2'b10
   } major_e;

   localparam int unsigned STEPS_PER_PHASE = 4;

   typedef struct packed {
      logic mem_read;
      logic pc_b1;
      logic one_b2;
      logic irlo_b1;
      logic idx_b2;
      logic mbr_b2;
      logic pass1;
      logic pass2;
      logic add;
      logic ld_mar;
      logic ld_pc;
      logic ld_ir;
   } strobe_t;

endpackage

// File: rtl/phseq_minor_timer.sv
module phseq_minor_timer #(
   parameter bit RING_STYLE = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   output logic [3:0] step_oh,
   output logic       last_step
);
   import phseq_pkg::*;

   localparam int unsigned CNT_W = $clog2(STEPS_PER_PHASE);

   generate
      if (RING_STYLE) begin : g_ring
         logic [STEPS_PER_PHASE-1:0] ring_q;
         always_ff @(posedge clk) begin
            if (rst) ring_q <= {{(STEPS_PER_PHASE-1){1'b0}}, 1'b1};
            else     ring_q <= {ring_q[STEPS_PER_PHASE-2:0], ring_q[STEPS_PER_PHASE-1]};
         end
         assign step_oh = ring_q;
      end else begin : g_binary
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (rst) cnt_q <= '0;
            else     cnt_q <= cnt_q + 1'b1;
         end
         for (genvar k = 0; k < STEPS_PER_PHASE; k++) begin : g_dec
            assign step_oh[k] = (cnt_q == CNT_W'(k));
         end
      end
   endgenerate

   assign last_step = step_oh[STEPS_PER_PHASE-1];

   AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $countones(step_oh) == 1); // R2
   AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      step_oh[0] |=> step_oh[1]); // R2
   AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
      last_step |=> step_oh[0]); // R2

endmodule

// File: rtl/phseq_opcode_decode.sv
module phseq_opcode_decode #(
   parameter int unsigned OPC_W           = 4,
   parameter logic [(1<<OPC_W)-1:0] ONE_OP_MASK     = 16'hF0EE,
   parameter logic [(1<<OPC_W)-1:0] FETCH_ONLY_MASK = 16'h0C01,
   parameter logic [(1<<OPC_W)-1:0] IO_MASK         = 16'h0300
) (
   input  logic [OPC_W-1:0]      opcode,
   input  logic                  ind_bit,
   output logic [(1<<OPC_W)-1:0] op_line,
   output logic                  is_one_op,
   output logic                  is_fetch_only,
   output logic                  is_io,
   output logic                  want_defer
);
   localparam int unsigned NUM_OPS = 1 << OPC_W;

   generate
      for (genvar k = 0; k < NUM_OPS; k++) begin : g_line
         assign op_line[k] = (opcode == OPC_W'(k));
      end
   endgenerate

   assign is_one_op     = |(op_line & ONE_OP_MASK);
   assign is_fetch_only = |(op_line & FETCH_ONLY_MASK);
   assign is_io         = |(op_line & IO_MASK);
   assign want_defer    = ind_bit & is_one_op;

endmodule

// File: rtl/phseq_major_fsm.sv
module phseq_major_fsm (
   input  logic              clk,
   input  logic              rst,
   input  logic              last_step,
   input  logic              is_fetch_only,
   input  logic              want_defer,
   input  logic              is_io,
   input  logic              io_done,
   output phseq_pkg::major_e major
);
   import phseq_pkg::*;

   major_e major_q, major_d;

   always_comb begin
      major_d = major_q;
      if (last_step) begin
         unique case (major_q)
            MAJ_FETCH: begin
               if (is_fetch_only)   major_d = MAJ_FETCH;
               else if (want_defer) major_d = MAJ_DEFER;
               else                 major_d = MAJ_EXEC;
            end
            MAJ_DEFER: major_d = MAJ_EXEC;
            MAJ_EXEC:  major_d = (is_io && !io_done) ? MAJ_EXEC : MAJ_FETCH;
            default:   major_d = MAJ_FETCH;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) major_q <= MAJ_FETCH;
      else     major_q <= major_d;
   end

   assign major = major_q;

   AST_MAJOR_HOLD_MIDPHASE: assert property (@(posedge clk) disable iff (rst)
      !last_step |=> $stable(major_q)); // R3
   AST_MAJOR_LEGAL: assert property (@(posedge clk) disable iff (rst)
      major_q != 2'b11); // R3
   AST_DEFER_THEN_EXEC: assert property (@(posedge clk) disable iff (rst)
      (major_q == MAJ_DEFER) && last_step |=> major_q == MAJ_EXEC); // R3
   AST_FETCH_ONLY_REPEATS: assert property (@(posedge clk) disable iff (rst)
      (major_q == MAJ_FETCH) && last_step && is_fetch_only |=> major_q == MAJ_FETCH); // R4
   AST_IO_WAIT: assert property (@(posedge clk) disable iff (rst)
      (major_q == MAJ_EXEC) && last_step && is_io && !io_done |=> major_q == MAJ_EXEC); // R5

endmodule

// File: rtl/phseq_strobe_gen.sv
module phseq_strobe_gen (
   input  phseq_pkg::major_e  major,
   input  logic [3:0]         step_oh,
   input  logic               is_one_op,
   input  logic               no_index,
   output phseq_pkg::strobe_t strobe
);
   import phseq_pkg::*;

   always_comb begin
      strobe = '0;
      unique case (major)
         MAJ_FETCH: begin
            if (step_oh[0]) begin
               strobe.pc_b1    = 1'b1;
               strobe.pass1    = 1'b1;
               strobe.ld_mar   = 1'b1;
               strobe.mem_read = 1'b1;
            end
            if (step_oh[1]) begin
               strobe.pc_b1  = 1'b1;
               strobe.one_b2 = 1'b1;
               strobe.add    = 1'b1;
               strobe.ld_pc  = 1'b1;
            end
            if (step_oh[2]) begin
               strobe.mbr_b2 = 1'b1;
               strobe.pass2  = 1'b1;
               strobe.ld_ir  = 1'b1;
            end
            if (step_oh[3] && is_one_op) begin
               strobe.irlo_b1 = 1'b1;
               strobe.ld_mar  = 1'b1;
               if (no_index) begin
                  strobe.pass1 = 1'b1;
               end else begin
                  strobe.idx_b2 = 1'b1;
                  strobe.add    = 1'b1;
               end
            end
         end
         MAJ_DEFER: begin
            if (step_oh[0]) strobe.mem_read = 1'b1;
            if (step_oh[2]) begin
               strobe.mbr_b2 = 1'b1;
               strobe.pass2  = 1'b1;
               strobe.ld_mar = 1'b1;
            end
         end
         default: strobe = '0;
      endcase
   end

endmodule

// File: rtl/phase_sequencer.sv
module phase_sequencer #(
   parameter int unsigned INSTR_W   = 16,
   parameter int unsigned OPC_W     = 4,
   parameter int unsigned IND_BIT   = 10,
   parameter bit          RING_STYLE = 1'b1,
   parameter logic [(1<<OPC_W)-1:0] ONE_OP_MASK     = 16'hF0EE,
   parameter logic [(1<<OPC_W)-1:0] FETCH_ONLY_MASK = 16'h0C01,
   parameter logic [(1<<OPC_W)-1:0] IO_MASK         = 16'h0300
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [INSTR_W-1:0]    instr,
   input  logic                  io_done,
   output logic [3:0]            minor_pulse,
   output logic [1:0]            major_state,
   output logic [(1<<OPC_W)-1:0] op_line,
   output logic                  mem_read,
   output logic                  pc_to_bus1,
   output logic                  one_to_bus2,
   output logic                  irlo_to_bus1,
   output logic                  idx_to_bus2,
   output logic                  mbr_to_bus2,
   output logic                  alu_pass1,
   output logic                  alu_pass2,
   output logic                  alu_add,
   output logic                  bus3_to_mar,
   output logic                  bus3_to_pc,
   output logic                  bus3_to_ir
);
   import phseq_pkg::*;

   localparam int unsigned OPC_LSB = INSTR_W - OPC_W;
   localparam int unsigned IDX_BIT = INSTR_W - 1;

   generate
      if (OPC_W >= INSTR_W) begin : g_bad_width
         $error("opcode field wider than instruction");
      end
      if (IND_BIT >= OPC_LSB) begin : g_bad_ind
         $error("indirect flag overlaps opcode field");
      end
      if ((ONE_OP_MASK & FETCH_ONLY_MASK) != '0) begin : g_bad_mask
         $error("an opcode cannot both take an operand and finish in fetch");
      end
      if (STEPS_PER_PHASE != 4) begin : g_bad_steps
         $error("minor step count must be four");
      end
   endgenerate

   logic       last_step;
   logic [3:0] step_oh;
   logic       is_one_op, is_fetch_only, is_io, want_defer;
   major_e     major;
   strobe_t    strobe;

   phseq_minor_timer #(.RING_STYLE(RING_STYLE)) u_timer (
      .clk       (clk),
      .rst       (rst),
      .step_oh   (step_oh),
      .last_step (last_step)
   );

   phseq_opcode_decode #(
      .OPC_W           (OPC_W),
      .ONE_OP_MASK     (ONE_OP_MASK),
      .FETCH_ONLY_MASK (FETCH_ONLY_MASK),
      .IO_MASK         (IO_MASK)
   ) u_decode (
      .opcode        (instr[INSTR_W-1:OPC_LSB]),
      .ind_bit       (instr[IND_BIT]),
      .op_line       (op_line),
      .is_one_op     (is_one_op),
      .is_fetch_only (is_fetch_only),
      .is_io         (is_io),
      .want_defer    (want_defer)
   );

   phseq_major_fsm u_major (
      .clk           (clk),
      .rst           (rst),
      .last_step     (last_step),
      .is_fetch_only (is_fetch_only),
      .want_defer    (want_defer),
      .is_io         (is_io),
      .io_done       (io_done),
      .major         (major)
   );

   phseq_strobe_gen u_strobe (
      .major     (major),
      .step_oh   (step_oh),
      .is_one_op (is_one_op),
      .no_index  (instr[IDX_BIT]),
      .strobe    (strobe)
   );

   assign minor_pulse  = step_oh;
   assign major_state  = major;
   assign mem_read     = strobe.mem_read;
   assign pc_to_bus1   = strobe.pc_b1;
   assign one_to_bus2  = strobe.one_b2;
   assign irlo_to_bus1 = strobe.irlo_b1;
   assign idx_to_bus2  = strobe.idx_b2;
   assign mbr_to_bus2  = strobe.mbr_b2;
   assign alu_pass1    = strobe.pass1;
   assign alu_pass2    = strobe.pass2;
   assign alu_add      = strobe.add;
   assign bus3_to_mar  = strobe.ld_mar;
   assign bus3_to_pc   = strobe.ld_pc;
   assign bus3_to_ir   = strobe.ld_ir;

   AST_OPLINE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $countones(op_line) == 1); // R6
   AST_READ_TO_MBR: assert property (@(posedge clk) disable iff (rst)
      mem_read |-> ##2 mbr_to_bus2); // R12
   AST_EXEC_QUIET: assert property (@(posedge clk) disable iff (rst)
      (major_state == 2'b10) |-> !(mem_read | bus3_to_mar | bus3_to_pc | bus3_to_ir)); // R11
   AST_SINGLE_ALU_OP: assert property (@(posedge clk) disable iff (rst)
      $countones({alu_pass1, alu_pass2, alu_add}) <= 1); // R10

endmodule

// File: tb/phase_sequencer_test.sv
module phase_sequencer_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] instr = 16'h0000;
   logic        io_done = 1'b0;
   logic [3:0]  minor_pulse;
   logic [1:0]  major_state;
   logic [15:0] op_line;
   logic mem_read, pc_to_bus1, one_to_bus2, irlo_to_bus1, idx_to_bus2, mbr_to_bus2;
   logic alu_pass1, alu_pass2, alu_add, bus3_to_mar, bus3_to_pc, bus3_to_ir;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   phase_sequencer uut (
      .clk(clk), .rst(rst), .instr(instr), .io_done(io_done),
      .minor_pulse(minor_pulse), .major_state(major_state), .op_line(op_line),
      .mem_read(mem_read), .pc_to_bus1(pc_to_bus1), .one_to_bus2(one_to_bus2),
      .irlo_to_bus1(irlo_to_bus1), .idx_to_bus2(idx_to_bus2), .mbr_to_bus2(mbr_to_bus2),
      .alu_pass1(alu_pass1), .alu_pass2(alu_pass2), .alu_add(alu_add),
      .bus3_to_mar(bus3_to_mar), .bus3_to_pc(bus3_to_pc), .bus3_to_ir(bus3_to_ir)
   );

   // reference state: step 0..3, phase 0 fetch / 1 defer / 2 execute
   int    m_step  = 0;
   int    m_phase = 0;
   string m_phase_tag = "R1";
   string m_step_tag  = "R1";

   function automatic bit is_one_op(input logic [3:0] o);
      return o inside {4'd1, 4'd2, 4'd3, 4'd5, 4'd6, 4'd7, 4'd12, 4'd13, 4'd14, 4'd15};
   endfunction
   function automatic bit is_fetch_only(input logic [3:0] o);
      return o inside {4'd0, 4'd10, 4'd11};
   endfunction
   function automatic bit is_io(input logic [3:0] o);
      return o inside {4'd8, 4'd9};
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_step = 0; m_phase = 0;
         m_phase_tag = "R1"; m_step_tag = "R1";
      end else begin
         m_step_tag = "R2";
         m_phase_tag = "R3";
         if (m_step == 3) begin
            if (m_phase == 0) begin
               m_phase_tag = "R4";
               if (is_fetch_only(instr[15:12]))                  m_phase = 0;
               else if (is_one_op(instr[15:12]) && instr[10])    m_phase = 1;
               else                                              m_phase = 2;
            end else if (m_phase == 1) begin
               m_phase = 2;
            end else begin
               m_phase_tag = "R5";
               m_phase = (is_io(instr[15:12]) && !io_done) ? 2 : 0;
            end
         end
         m_step = (m_step + 1) % 4;
      end
   end

   // expected strobe vector order:
   // {read, pc_b1, one_b2, irlo_b1, idx_b2, mbr_b2, pass1, pass2, add, ld_mar, ld_pc, ld_ir}
   function automatic logic [11:0] exp_strobes(input int ph, input int st, input logic [15:0] ir);
      logic [11:0] v = '0;
      if (ph == 0) begin
         case (st)
            0: v = 12'b1100_0010_0100;
            1: v = 12'b0110_0000_1010;
            2: v = 12'b0000_0101_0001;
            default: begin
               if (is_one_op(ir[15:12])) begin
                  if (ir[15]) v = 12'b0001_0010_0100;
                  else        v = 12'b0001_1000_1100;
               end
            end
         endcase
      end else if (ph == 1) begin
         if (st == 0) v = 12'b1000_0000_0000;
         if (st == 2) v = 12'b0000_0101_0100;
      end
      return v;
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   logic [15:0] prog [16] = '{
      16'h1005, 16'h1405, 16'h3105, 16'hD005, 16'hD405, 16'h4000, 16'h0000, 16'hA000,
      16'hB400, 16'h8000, 16'h9400, 16'h5000, 16'hE205, 16'hF7FF, 16'hC000, 16'h7400
   };

   initial begin
      logic [7:0]  lf = 8'hA5;
      logic [1:0]  rd_hist = '0;
      int          pc = 0;
      int          cyc = 0;
      string       stag;
      logic [11:0] act_v;
      instr = prog[0];
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk("R1", "reset step", {28'd0, minor_pulse}, 32'h1);
      chk("R1", "reset phase", {30'd0, major_state}, 32'h0);
      while (cyc < 6000) begin
         @(negedge clk);
         cyc++;
         // mid-run reset, landing inside a phase
         if (cyc == 3001) rst = 1'b1;
         if (cyc == 3004) rst = 1'b0;
         if (m_phase == 0 && m_step == 2) begin
            pc = (pc + 1) % 16;
            instr = prog[pc];
         end
         lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
         io_done = (lf[1:0] == 2'b00);
         #1;
         chk(m_step_tag, "minor step", {28'd0, minor_pulse}, 32'(4'b0001 << m_step));
         chk(m_phase_tag, "major phase", {30'd0, major_state}, 32'(m_phase));
         chk("R6", "opcode lines", {16'd0, op_line}, 32'(16'h0001 << instr[15:12]));
         if (m_phase == 0)
            stag = (m_step == 0) ? "R7" : (m_step == 1) ? "R8" : (m_step == 2) ? "R9" : "R10";
         else
            stag = "R11";
         act_v = {mem_read, pc_to_bus1, one_to_bus2, irlo_to_bus1, idx_to_bus2, mbr_to_bus2,
                  alu_pass1, alu_pass2, alu_add, bus3_to_mar, bus3_to_pc, bus3_to_ir};
         chk(stag, "strobes", {20'd0, act_v}, {20'd0, exp_strobes(m_phase, m_step, instr)});
         if (rd_hist[1]) chk("R12", "read to buffer latency", {31'd0, mbr_to_bus2}, 32'd1);
         if (rst) rd_hist = '0;
         else     rd_hist = {rd_hist[0], mem_read};
      end
      finish_run();
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

endmodule